// File: doc/BRIEF.md
# SCCB Camera Control Bus Master

This block drives the two-wire serial control bus used to program image sensors. A host presents one command at a time on a valid/ready handshake: a 7-bit device identifier, an 8-bit register index, an 8-bit write value and a read select. The block then runs the whole bus sequence by itself and pulses a completion strobe. For a read, it also returns the byte the sensor supplied.

A write is one framed transfer of three 9-bit phases. A read is two framed transfers. The first transfer sends the identifier with direction bit 0 and the register index. The second sends the identifier with direction bit 1 and then receives one byte from the sensor. The ninth bit of every phase is a don't-care slot: no acknowledge is demanded. All bus timing comes from a clock enable that fires every `QTR_CYCLES` system clocks. One bus bit spans four such quarter periods, so a 100 kHz bus needs `QTR_CYCLES` equal to the system clock rate divided by 400 kHz.

The data line is open-drain style. The block provides an enable and a value for its driver and reads the resolved line back on `sda_in`. The clock line is always driven.

Top module: `sccb_master`

## Requirements
- R1: Out of reset and whenever no command is in progress, `scl_o` is 1, `sda_oe` is 0, `cmd_ready` is 1 and `rsp_done` is 0.
- R2: From the cycle a command is accepted until the transaction completes, `cmd_ready` is 0. A `cmd_valid` presented in that window starts nothing and does not change the bytes sent.
- R3: When `cmd_rd` is 0, the bus carries one start, then the phases {id,0}, sub, wdata, then one stop. Each phase is 8 bits, most significant bit first, plus a ninth bit.
- R4: When `cmd_rd` is 1, the bus carries start, {id,0}, sub, stop, start, {id,1}, a byte from the sensor, stop. `rsp_rdata` then equals the byte the sensor sent, most significant bit first.
- R5: Outside start and stop conditions, the data line changes only while `scl_o` is 0. A mid-phase change with the clock high would appear as an extra start or stop.
- R6: A start is the data line falling from 1 to 0 while the clock is high, followed by the clock falling. A stop is the data line rising from 0 to 1 while the clock is high, after the clock has risen.
- R7: During the ninth bit of every phase the master writes, `sda_oe` is 0. The level the sensor puts there has no effect on the sequence or on completion.
- R8: During the received-byte phase, `sda_oe` is 0 for all eight data bits. During its ninth bit, the master drives the line to 1.
- R9: Every clock-high interval inside a transfer lasts exactly 2×`QTR_CYCLES` system clocks. A bit lasts 4×`QTR_CYCLES`.
- R10: `rsp_done` is a one-cycle pulse at the end of each transaction, and `cmd_ready` is 1 in that cycle. `rsp_rdata` changes only when a read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_rd | input | 1 | 1 selects a read, 0 a write |
| cmd_id | input | 7 | Target device identifier |
| cmd_sub | input | 8 | Register index inside the device |
| cmd_wdata | input | 8 | Byte to write (unused for reads) |
| rsp_done | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 8 | Byte returned by the last read |
| scl_o | output | 1 | Serial clock line |
| sda_oe | output | 1 | Data line driver enable |
| sda_out | output | 1 | Data line driven level |
| sda_in | input | 1 | Resolved data line level |

## Verification
Writes are tried with a mixed pattern and with all-ones and all-zeros bytes. They run once with the sensor holding the ninth-bit slot low and once with it high. This shows that identifier, direction bit and byte order are right at both data extremes, and that the don't-care slot is truly ignored. Reads use two returned bytes of opposite bit polarity, which separates a shifted or inverted capture from a correct one. A read followed by a write shows whether `rsp_rdata` is held. A command pushed while the block is busy shows whether a late request can leak into the transfer under way.

// File: rtl/sccb_pkg.sv
package sccb_pkg;
  localparam int ID_W   = 7;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 3;
  localparam int BIT_W  = 4;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W);

  typedef enum logic [1:0] {SL_START, SL_BYTE, SL_STOP} slot_e;

  // Slot sequence: write = S B B B P ; read = S B B P S B B P
  function automatic slot_e slot_kind(input logic rd, input logic [STEP_W-1:0] step);
    if (!rd) begin
      if (step == 3'd0) return SL_START;
      if (step == 3'd4) return SL_STOP;
      return SL_BYTE;
    end
    case (step)
      3'd0, 3'd4: return SL_START;
      3'd3, 3'd7: return SL_STOP;
      default:    return SL_BYTE;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] last_step(input logic rd);
    return rd ? 3'd7 : 3'd4;
  endfunction

  function automatic logic rx_phase(input logic rd, input logic [STEP_W-1:0] step);
    return rd && (step == 3'd6);
  endfunction

  function automatic logic [BYTE_W-1:0] phase_byte(input logic rd,
      input logic [STEP_W-1:0] step, input logic [ID_W-1:0] id,
      input logic [BYTE_W-1:0] sub, input logic [BYTE_W-1:0] wd);
    case (step)
      3'd1:    return {id, 1'b0};
      3'd2:    return sub;
      3'd3:    return rd ? '0 : wd;
      3'd5:    return {id, 1'b1};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sccb_tick.sv
module sccb_tick #(
  parameter int DIV = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sccb_seq.sv
module sccb_seq
  import sccb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic              cmd_rd,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [BYTE_W-1:0] cmd_sub,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              sda_in,
  output logic              busy,
  output logic              scl_o,
  output logic              sda_oe,
  output logic              sda_out,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              in_ctrl,
  output logic              sample_evt
);
  logic              busy_q, rd_q, oe_q, out_q, done_q;
  logic [ID_W-1:0]   id_q;
  logic [BYTE_W-1:0] sub_q, wd_q, sh_q, rdata_q;
  logic [STEP_W-1:0] step_q, nstep;
  logic [BIT_W-1:0]  bit_q, nbit;
  logic [1:0]        qtr_q, nqtr;
  slot_e             kind, nkind;
  logic              slot_end, fin, noe, nout;
  logic [BYTE_W-1:0] nbyte;

  always_comb begin
    kind     = slot_kind(rd_q, step_q);
    slot_end = (qtr_q == 2'd3) && ((kind != SL_BYTE) || (bit_q == BIT_LAST));
    fin      = slot_end && (step_q == last_step(rd_q));
    nstep    = step_q;
    nbit     = bit_q;
    nqtr     = qtr_q + 2'd1;
    if (slot_end) begin
      nstep = step_q + 3'd1;
      nbit  = '0;
    end else if (qtr_q == 2'd3) begin
      nbit  = bit_q + 4'd1;
    end
    nkind = slot_kind(rd_q, nstep);
    nbyte = phase_byte(rd_q, nstep, id_q, sub_q, wd_q);
    noe   = oe_q;
    nout  = out_q;
    case (nkind)
      SL_START: begin
        noe  = 1'b1;
        nout = (nqtr < 2'd2);
      end
      SL_STOP: if (nqtr != 2'd0) begin
        noe  = 1'b1;
        nout = (nqtr == 2'd3);
      end
      default: if (nqtr == 2'd1) begin
        if (nbit == BIT_LAST) begin
          noe  = rx_phase(rd_q, nstep);
          nout = 1'b1;
        end else if (rx_phase(rd_q, nstep)) begin
          noe  = 1'b0;
          nout = 1'b1;
        end else begin
          noe  = 1'b1;
          nout = nbyte[3'd7 - nbit[2:0]];
        end
      end
    endcase
    sample_evt = busy_q && tick && (kind == SL_BYTE) && rx_phase(rd_q, step_q)
                 && (bit_q < BIT_LAST) && (qtr_q == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0; rd_q <= 1'b0; oe_q <= 1'b0; out_q <= 1'b1; done_q <= 1'b0;
      id_q <= '0; sub_q <= '0; wd_q <= '0; sh_q <= '0; rdata_q <= '0;
      step_q <= '0; bit_q <= '0; qtr_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (cmd_valid) begin
          busy_q <= 1'b1;
          rd_q   <= cmd_rd;
          id_q   <= cmd_id;
          sub_q  <= cmd_sub;
          wd_q   <= cmd_wdata;
          step_q <= '0;
          bit_q  <= '0;
          qtr_q  <= '0;
          oe_q   <= 1'b1;
          out_q  <= 1'b1;
        end
      end else if (tick) begin
        if (sample_evt) sh_q <= {sh_q[BYTE_W-2:0], sda_in};
        if (fin) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          out_q  <= 1'b1;
          done_q <= 1'b1;
          if (rd_q) rdata_q <= sh_q;
        end else begin
          step_q <= nstep;
          bit_q  <= nbit;
          qtr_q  <= nqtr;
          oe_q   <= noe;
          out_q  <= nout;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign scl_o   = !busy_q || (kind == SL_START) || qtr_q[1];
  assign sda_oe  = oe_q;
  assign sda_out = out_q;
  assign done    = done_q;
  assign rdata   = rdata_q;
  assign in_ctrl = busy_q && (kind != SL_BYTE);
endmodule

// File: rtl/sccb_master.sv
module sccb_master
  import sccb_pkg::*;
#(
  parameter int QTR_CYCLES = 250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_rd,
  input  logic [ID_W-1:0]   cmd_id,
  input  logic [BYTE_W-1:0] cmd_sub,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              scl_o,
  output logic              sda_oe,
  output logic              sda_out,
  input  logic              sda_in
);
  logic busy, tick, in_ctrl, sample_evt;

  sccb_tick #(.DIV(QTR_CYCLES)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  sccb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid),
    .cmd_rd(cmd_rd), .cmd_id(cmd_id), .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata),
    .sda_in(sda_in), .busy(busy), .scl_o(scl_o), .sda_oe(sda_oe),
    .sda_out(sda_out), .done(rsp_done), .rdata(rsp_rdata),
    .in_ctrl(in_ctrl), .sample_evt(sample_evt)
  );

  assign cmd_ready = !busy;
endmodule

// File: rtl/sccb_master_chk.sv
module sccb_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_done,
  input logic scl_o,
  input logic sda_oe,
  input logic sda_out,
  input logic busy,
  input logic tick,
  input logic in_ctrl,
  input logic sample_evt
);
  // R1: idle bus is clock high, data released
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));

  // R2: an accepted command drops ready on the next cycle
  a_r2_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R2: a transaction only starts from a presented command
  a_r2_start_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  // R5: a data change with the clock held high belongs to a start or stop slot
  a_r5_data_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && sda_oe && $past(sda_oe) && (sda_out != $past(sda_out)))
      |-> in_ctrl);

  // R8: the line is released whenever a received bit is captured
  a_r8_sample_released: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> !sda_oe);

  // R9: the clock line only moves after a quarter-period tick
  a_r9_scl_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(scl_o));

  // R10: completion is a single-cycle pulse seen while idle
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> cmd_ready);
endmodule

bind sccb_master sccb_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_done(rsp_done), .scl_o(scl_o), .sda_oe(sda_oe), .sda_out(sda_out),
  .busy(busy), .tick(tick), .in_ctrl(in_ctrl), .sample_evt(sample_evt)
);

// File: tb/sccb_master_tb.sv
module sccb_master_tb_top;
  localparam int Q = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_rd = 1'b0;
  logic [6:0] cmd_id = '0;
  logic [7:0] cmd_sub = '0, cmd_wdata = '0;
  logic cmd_ready, rsp_done, scl_o, sda_oe, sda_out, sda_in;
  logic [7:0] rsp_rdata;

  always #4 clk = ~clk;

  sccb_master #(.QTR_CYCLES(Q)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_rd(cmd_rd), .cmd_id(cmd_id), .cmd_sub(cmd_sub), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .scl_o(scl_o), .sda_oe(sda_oe),
    .sda_out(sda_out), .sda_in(sda_in)
  );

  int nchk = 0, nerr = 0;

  // bus model and sensor-side slave
  logic ack_lvl = 1'b0, rd_mode = 1'b0;
  logic [7:0] slv_byte = 8'h00;
  int slv_bit = 0, slv_ph = 0;
  logic slave_lvl;
  always_comb begin
    if (rd_mode && slv_ph == 3 && slv_bit < 8) slave_lvl = slv_byte[7 - slv_bit];
    else if (slv_bit == 8)                     slave_lvl = ack_lvl;
    else                                       slave_lvl = 1'b1;
  end
  assign sda_in = sda_oe ? sda_out : slave_lvl;

  // passive monitor
  logic p_scl = 1'b1, p_bus = 1'b1, hi_run = 1'b0;
  logic [8:0] cur = '0, msk = '0;
  logic [7:0] bytes [0:7];
  logic [8:0] oem [0:7];
  logic       ninth [0:7];
  int starts = 0, stops = 0, nbytes = 0, bitcnt = 0, ndone = 0;
  int hi_len = 0, hi_min = 0, hi_max = 0;

  task automatic mon_clear();
    starts = 0; stops = 0; nbytes = 0; bitcnt = 0; ndone = 0;
    hi_min = 1000000; hi_max = 0; hi_run = 1'b0; slv_bit = 0; slv_ph = 0;
  endtask

  always @(negedge clk) begin
    if (rsp_done) ndone++;
    if (!p_scl && scl_o) begin
      cur = {cur[7:0], sda_in};
      msk = {msk[7:0], sda_oe};
      bitcnt++;
      hi_run = 1'b1; hi_len = 0;
      if (bitcnt == 9) begin
        if (nbytes < 8) begin
          bytes[nbytes] = cur[8:1]; oem[nbytes] = msk; ninth[nbytes] = cur[0];
        end
        nbytes++; bitcnt = 0;
      end
    end
    if (p_scl && scl_o && p_bus && !sda_in) begin starts++; bitcnt = 0; hi_run = 1'b0; end
    if (p_scl && scl_o && !p_bus && sda_in) begin stops++; bitcnt = 0; end
    if (scl_o && hi_run) hi_len++;
    if (p_scl && !scl_o) begin
      if (hi_run) begin
        if (hi_len < hi_min) hi_min = hi_len;
        if (hi_len > hi_max) hi_max = hi_len;
      end
      hi_run = 1'b0;
      slv_bit = bitcnt; slv_ph = nbytes;
    end
    p_scl = scl_o; p_bus = sda_in;
  end

  task automatic chk_eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic rd, input logic [6:0] id, input logic [7:0] sub, input logic [7:0] wd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = rd; cmd_id = id; cmd_sub = sub; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!rsp_done && n < 5000) begin @(negedge clk); n++; end
    chk_eq("R10 completion seen", int'(n < 5000), 1);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk_eq("R1 scl high", scl_o, 1);
    chk_eq("R1 data released", sda_oe, 0);
    chk_eq("R1 ready", cmd_ready, 1);
    chk_eq("R1 no done", rsp_done, 0);
  endtask

  task automatic t_write(input logic [6:0] id, input logic [7:0] sub, input logic [7:0] wd, input logic ack);
    ack_lvl = ack; rd_mode = 1'b0; mon_clear();
    issue(1'b0, id, sub, wd);
    wait_done();
    chk_eq("R3 phase count", nbytes, 3);
    chk_eq("R3 id phase", bytes[0], {id, 1'b0});
    chk_eq("R3 sub phase", bytes[1], sub);
    chk_eq("R3 data phase", bytes[2], wd);
    chk_eq("R3 data bits driven", {oem[0][8:1], oem[1][8:1], oem[2][8:1]}, 24'hFFFFFF);
    chk_eq("R5 start count", starts, 1);
    chk_eq("R6 stop count", stops, 1);
    chk_eq("R7 ninth bits released", {oem[0][0], oem[1][0], oem[2][0]}, 0);
    chk_eq("R9 scl high min", hi_min, 2 * Q);
    chk_eq("R9 scl high max", hi_max, 2 * Q);
    chk_eq("R10 one done pulse", ndone, 1);
    chk_eq("R1 idle after write", {scl_o, sda_oe, cmd_ready}, 3'b101);
  endtask

  task automatic t_read(input logic [6:0] id, input logic [7:0] sub, input logic [7:0] rb);
    ack_lvl = 1'b0; rd_mode = 1'b1; slv_byte = rb; mon_clear();
    issue(1'b1, id, sub, 8'h00);
    wait_done();
    chk_eq("R4 phase count", nbytes, 4);
    chk_eq("R4 write id phase", bytes[0], {id, 1'b0});
    chk_eq("R4 sub phase", bytes[1], sub);
    chk_eq("R4 read id phase", bytes[2], {id, 1'b1});
    chk_eq("R4 bus byte", bytes[3], rb);
    chk_eq("R4 rdata", rsp_rdata, rb);
    chk_eq("R6 two starts", starts, 2);
    chk_eq("R6 two stops", stops, 2);
    chk_eq("R8 read phase drive mask", oem[3], 9'h001);
    chk_eq("R8 ninth bit high", ninth[3], 1);
    chk_eq("R9 scl high max", hi_max, 2 * Q);
    chk_eq("R10 one done pulse", ndone, 1);
  endtask

  task automatic t_busy_ignore();
    ack_lvl = 1'b0; rd_mode = 1'b0; mon_clear();
    issue(1'b0, 7'h15, 8'h3C, 8'h81);
    repeat (20) @(negedge clk);
    cmd_valid = 1'b1; cmd_rd = 1'b1; cmd_id = 7'h6A; cmd_sub = 8'hEE; cmd_wdata = 8'h11;
    @(negedge clk);
    chk_eq("R2 ready low while busy", cmd_ready, 0);
    repeat (10) @(negedge clk);
    cmd_valid = 1'b0;
    wait_done();
    chk_eq("R2 id unchanged", bytes[0], {7'h15, 1'b0});
    chk_eq("R2 sub unchanged", bytes[1], 8'h3C);
    chk_eq("R2 data unchanged", bytes[2], 8'h81);
    repeat (40) @(negedge clk);
    chk_eq("R2 no extra transfer", starts, 1);
    chk_eq("R2 single done", ndone, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write(7'h30, 8'h12, 8'hA5, 1'b0);
    t_write(7'h7F, 8'hFF, 8'h00, 1'b1);
    t_read(7'h30, 8'h0A, 8'h26);
    t_read(7'h21, 8'h5B, 8'hD9);
    t_write(7'h00, 8'h00, 8'hFF, 1'b1);
    chk_eq("R10 rdata held over write", rsp_rdata, 8'hD9);
    t_busy_ignore();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule